// File: doc/BRIEF.md
# IN Endpoint Bank Queue with Last-Bank Withdrawal

This block keeps account of the packet banks that firmware has filled for one device-side IN endpoint of a USB function. Firmware offers a filled bank on a valid/ready handshake. The serial engine signals that an IN token has claimed the oldest bank, and later that the bank has gone out on the wire. The block reports how many banks are busy, which bank index is transmitted next or is being transmitted, and whether a transmit is in progress.

Software can ask to withdraw the newest queued bank with a one-cycle kill strobe. The request stays pending until it resolves. It resolves in one of three ways: the bank is discarded, the bank goes out anyway because the serial engine already owns it, or there was nothing to withdraw. An interrupt enable with separate set and clear strobes gates a level interrupt that is raised while any bank is busy.

The bank-write interface follows these back-pressure rules. A bank counts as written only in a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is low while every bank is busy and while a kill is pending. A raised `wr_valid` may be held or dropped freely, because the block stores no payload. All other pins are plain single-cycle strobes or levels.

Top module: `in_bank_kill_ctrl`

## Requirements
- R1: After reset, `busy_cnt`=0, `kill_pend`=0, `tx_active`=0, `tx_bank`=0, `ien`=0, `busy_irq`=0 and `wr_ready`=1.
- R2: `wr_ready` equals (busy_cnt < NUM_BANKS) and not kill_pend. A handshake completed with `wr_valid`=1 and `wr_ready`=1 raises `busy_cnt` by one on the next edge. `wr_valid` has no effect while `wr_ready` is low.
- R3: An `in_token` that arrives with no transmit in progress and `busy_cnt`>0 sets `tx_active` on the next edge. `tx_bank` names the oldest bank, and indices run 0 to NUM_BANKS-1 and wrap. A `pkt_sent` during a transmit clears `tx_active`, lowers `busy_cnt` by one and advances `tx_bank` by one, modulo NUM_BANKS. A token that arrives during a transmit or with no busy bank has no effect, and neither does a `pkt_sent` that arrives with no transmit in progress.
- R4: A `kill_set` that arrives while `kill_pend` is low sets `kill_pend` on the next edge. A `kill_set` that arrives while `kill_pend` is high is ignored.
- R5: Suppose a kill is pending, `busy_cnt`>=1, and the newest bank is not in flight. Then on the next edge the newest bank is discarded: `busy_cnt` drops by one, `kill_pend` clears, and `tx_bank` is unchanged.
- R6: A pending kill with `busy_cnt`=0 clears on the next edge and leaves `busy_cnt` at 0.
- R7: The newest bank is in flight when `busy_cnt`=1 and either a transmit is in progress or an `in_token` arrives in the same cycle. In that case the kill is refused: `kill_pend` stays high and the bank is transmitted. The completing `pkt_sent` lowers `busy_cnt` to 0 and clears `kill_pend` on the same edge.
- R8: Suppose `busy_cnt`>=2 and an `in_token` arrives while a kill is pending. Then the oldest bank is transmitted and the newest is discarded, so the count falls by two over the whole exchange.
- R9: `ien` is set by `ien_set`=1 and cleared by `ien_clr`=1, and clear wins when both are 1. With both strobes at 0, `ien` holds its value.
- R10: `busy_irq` is 1 exactly when `ien`=1 and `busy_cnt`>0.
- R11: `busy_cnt` never exceeds NUM_BANKS and never wraps below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Firmware offers a filled bank |
| wr_ready | output | 1 | Block accepts a filled bank this cycle |
| in_token | input | 1 | IN token received, one-cycle strobe |
| pkt_sent | input | 1 | Current bank fully transmitted, one-cycle strobe |
| kill_set | input | 1 | Request to withdraw the newest bank |
| ien_set | input | 1 | Set the busy-bank interrupt enable |
| ien_clr | input | 1 | Clear the busy-bank interrupt enable |
| busy_cnt | output | $clog2(NUM_BANKS+1) | Number of busy banks |
| kill_pend | output | 1 | Withdrawal request outstanding |
| tx_active | output | 1 | A bank is on the wire |
| tx_bank | output | max(1,$clog2(NUM_BANKS)) | Index of the oldest bank, the one in transmit |
| ien | output | 1 | Busy-bank interrupt enable |
| busy_irq | output | 1 | Busy-bank interrupt request |

## Verification
The properties assume that `pkt_sent` only ever closes a transmit that a token opened. They also assume that every strobe is a level sampled at a single edge, so it may stay high on several cycles back to back. The random stimulus drives `pkt_sent` mostly while the reference model shows a transmit in progress. It also sends rare stray `pkt_sent` strobes while idle, which lets the ignore rule of R3 be seen at the ports. Directed sequences place tokens in the same cycle as a pending kill, both with one busy bank and with several, to reach the refusal and double-drop outcomes.

// File: rtl/in_bank_kill_pkg.sv
package in_bank_kill_pkg;
  typedef struct packed {
    logic drop;
    logic done;
  } kill_res_t;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bank_ring.sv
module bank_ring #(
  parameter int NUM_BANKS = 3,
  parameter int CNT_W     = 2,
  parameter int IDX_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             drop,
  input  logic             in_token,
  input  logic             pkt_sent,
  output logic [CNT_W-1:0] cnt,
  output logic             sending,
  output logic [IDX_W-1:0] rd_idx,
  output logic             tok_take,
  output logic             sent_ev
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BANKS - 1);

  assign tok_take = in_token && !sending && (cnt != '0);
  assign sent_ev  = pkt_sent && sending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      sending <= 1'b0;
      rd_idx  <= '0;
    end else begin
      cnt <= cnt + CNT_W'(push) - CNT_W'(sent_ev) - CNT_W'(drop);
      if (sent_ev) begin
        sending <= 1'b0;
        rd_idx  <= (rd_idx == LAST_IDX) ? '0 : rd_idx + 1'b1;
      end else if (tok_take) begin
        sending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/kill_arbiter.sv
module kill_arbiter #(
  parameter int CNT_W = 2
) (
  input  logic                          pend,
  input  logic [CNT_W-1:0]              cnt,
  input  logic                          sending,
  input  logic                          tok_take,
  input  logic                          sent_ev,
  output in_bank_kill_pkg::kill_res_t   res
);
  logic newest_in_flight;

  assign newest_in_flight = (cnt == CNT_W'(1)) && (sending || tok_take);

  always_comb begin
    res = '0;
    if (pend) begin
      if (cnt == '0) begin
        res.done = 1'b1;
      end else if (newest_in_flight) begin
        res.done = sent_ev;
      end else begin
        res.drop = 1'b1;
        res.done = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_enable.sv
module irq_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic set_stb,
  input  logic clr_stb,
  input  logic busy,
  output logic en,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en <= 1'b0;
    else if (clr_stb) en <= 1'b0;
    else if (set_stb) en <= 1'b1;
  end

  assign irq = en && busy;
endmodule

// File: rtl/in_bank_kill_ctrl.sv
module in_bank_kill_ctrl #(
  parameter int NUM_BANKS = 3,
  localparam int CNT_W = $clog2(NUM_BANKS + 1),
  localparam int IDX_W = in_bank_kill_pkg::idx_width(NUM_BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic             in_token,
  input  logic             pkt_sent,
  input  logic             kill_set,
  input  logic             ien_set,
  input  logic             ien_clr,
  output logic [CNT_W-1:0] busy_cnt,
  output logic             kill_pend,
  output logic             tx_active,
  output logic [IDX_W-1:0] tx_bank,
  output logic             ien,
  output logic             busy_irq
);
  in_bank_kill_pkg::kill_res_t res;
  logic tok_take, sent_ev, push;

  assign wr_ready = (busy_cnt < CNT_W'(NUM_BANKS)) && !kill_pend;
  assign push     = wr_valid && wr_ready;

  bank_ring #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W), .IDX_W(IDX_W)) ring_i (
    .clk(clk), .rst_n(rst_n), .push(push), .drop(res.drop),
    .in_token(in_token), .pkt_sent(pkt_sent), .cnt(busy_cnt),
    .sending(tx_active), .rd_idx(tx_bank), .tok_take(tok_take),
    .sent_ev(sent_ev)
  );

  kill_arbiter #(.CNT_W(CNT_W)) arb_i (
    .pend(kill_pend), .cnt(busy_cnt), .sending(tx_active),
    .tok_take(tok_take), .sent_ev(sent_ev), .res(res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     kill_pend <= 1'b0;
    else if (res.done)              kill_pend <= 1'b0;
    else if (kill_set && !kill_pend) kill_pend <= 1'b1;
  end

  irq_enable ien_i (
    .clk(clk), .rst_n(rst_n), .set_stb(ien_set), .clr_stb(ien_clr),
    .busy(busy_cnt != '0), .en(ien), .irq(busy_irq)
  );
endmodule

// File: rtl/in_bank_kill_ctrl_chk.sv
module in_bank_kill_ctrl_chk #(
  parameter int NUM_BANKS = 3,
  localparam int CNT_W = $clog2(NUM_BANKS + 1),
  localparam int IDX_W = in_bank_kill_pkg::idx_width(NUM_BANKS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             in_token,
  input logic             pkt_sent,
  input logic             kill_set,
  input logic             ien_set,
  input logic             ien_clr,
  input logic [CNT_W-1:0] busy_cnt,
  input logic             kill_pend,
  input logic             tx_active,
  input logic [IDX_W-1:0] tx_bank,
  input logic             ien,
  input logic             busy_irq
);
  // R11
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= CNT_W'(NUM_BANKS));

  // R2
  push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !(pkt_sent && tx_active)) |=> busy_cnt == $past(busy_cnt) + 1'b1);

  // R2
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt == CNT_W'(NUM_BANKS)) |-> !wr_ready);

  // R4
  kill_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_set && !kill_pend) |=> kill_pend);

  // R5
  kill_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_pend && busy_cnt >= CNT_W'(2) && !pkt_sent) |=> (!kill_pend && busy_cnt == $past(busy_cnt) - 1'b1));

  // R6
  kill_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_pend && busy_cnt == '0) |=> (!kill_pend && busy_cnt == '0));

  // R7
  kill_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_pend && busy_cnt == CNT_W'(1) && tx_active && !pkt_sent) |=> kill_pend);

  // R9
  ien_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ien_clr |=> !ien);

  // R9
  ien_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_set && !ien_clr) |=> ien);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien || busy_cnt == '0) |-> !busy_irq);
endmodule

bind in_bank_kill_ctrl in_bank_kill_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (.*);

// File: tb/in_bank_kill_ctrl_tb_top.sv
`timescale 1ns/1ps
module in_bank_kill_ctrl_tb_top;
  localparam int NB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 0, in_token = 0, pkt_sent = 0, kill_set = 0, ien_set = 0, ien_clr = 0;
  logic wr_ready, kill_pend, tx_active, ien, busy_irq;
  logic [1:0] busy_cnt;
  logic [1:0] tx_bank;

  always #4 clk = ~clk;

  in_bank_kill_ctrl #(.NUM_BANKS(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .in_token(in_token), .pkt_sent(pkt_sent), .kill_set(kill_set),
    .ien_set(ien_set), .ien_clr(ien_clr), .busy_cnt(busy_cnt),
    .kill_pend(kill_pend), .tx_active(tx_active), .tx_bank(tx_bank),
    .ien(ien), .busy_irq(busy_irq)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done_flag = 0;

  // behavioural reference: a queue of bank indices
  int q[$];
  int m_next = 0;
  int m_rd = 0;
  bit m_send = 0;
  bit m_kill = 0;
  bit m_en = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_next = 0; m_rd = 0; m_send = 0; m_kill = 0; m_en = 0;
    end else begin
      bit take, sent, drop, fin, acc;
      acc  = wr_valid && q.size() < NB && !m_kill;
      take = in_token && !m_send && q.size() > 0;
      sent = pkt_sent && m_send;
      drop = 0; fin = 0;
      if (m_kill) begin
        if (q.size() == 0) fin = 1;
        else if (q.size() == 1 && (m_send || take)) fin = sent;
        else begin drop = 1; fin = 1; end
      end
      if (sent) begin void'(q.pop_front()); m_rd = (m_rd + 1) % NB; m_send = 0; end
      else if (take) m_send = 1;
      if (drop) begin void'(q.pop_back()); m_next = (m_next + NB - 1) % NB; end
      if (acc) begin q.push_back(m_next); m_next = (m_next + 1) % NB; end
      if (fin) m_kill = 0;
      else if (kill_set && !m_kill) m_kill = 1;
      if (ien_clr) m_en = 0;
      else if (ien_set) m_en = 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R11 busy_cnt", busy_cnt, q.size());
    chk("R2 wr_ready", wr_ready, (q.size() < NB) && !m_kill);
    chk("R4 kill_pend", kill_pend, m_kill);
    chk("R3 tx_active", tx_active, m_send);
    chk("R3 tx_bank", tx_bank, m_rd);
    chk("R9 ien", ien, m_en);
    chk("R10 busy_irq", busy_irq, m_en && q.size() > 0);
  endtask

  // drive at negedge, one clock, compare at following negedge
  task automatic step(input bit w, input bit t, input bit s, input bit k, input bit es, input bit ec);
    wr_valid = w; in_token = t; pkt_sent = s; kill_set = k; ien_set = es; ien_clr = ec;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 0; in_token = 0; pkt_sent = 0; kill_set = 0; ien_set = 0; ien_clr = 0;
    compare_all();
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy_cnt", busy_cnt, 0);
    chk("R1 kill_pend", kill_pend, 0);
    chk("R1 tx_active", tx_active, 0);
    chk("R1 tx_bank", tx_bank, 0);
    chk("R1 ien", ien, 0);
    chk("R1 busy_irq", busy_irq, 0);
    chk("R1 wr_ready", wr_ready, 1);

    // R3 ignored strobes on an empty queue
    step(0,1,0,0,0,0); chk("R3 token on empty", tx_active, 0);
    step(0,0,1,0,0,0); chk("R3 stray sent", busy_cnt, 0);

    // R2 fill and back-pressure
    step(1,0,0,0,0,0); step(1,0,0,0,0,0); step(1,0,0,0,0,0);
    chk("R2 filled", busy_cnt, 3);
    chk("R2 ready low when full", wr_ready, 0);
    step(1,0,0,0,0,0); chk("R11 write when full ignored", busy_cnt, 3);

    // R9 / R10 enable handling
    step(0,0,0,0,1,0); chk("R9 set", ien, 1); chk("R10 irq", busy_irq, 1);
    step(0,0,0,0,0,0); chk("R9 hold", ien, 1);
    step(0,0,0,0,1,1); chk("R9 clear wins", ien, 0);
    step(0,0,0,0,1,0);

    // R5 discard newest with three queued
    step(0,0,0,1,0,0); chk("R4 raised", kill_pend, 1);
    chk("R2 ready low while pending", wr_ready, 0);
    step(1,0,0,1,0,0); chk("R5 count after discard", busy_cnt, 2);
    chk("R5 flag cleared", kill_pend, 0); chk("R5 tx_bank kept", tx_bank, 0);

    // R8 token with pending kill and two banks
    step(0,0,0,1,0,0);
    step(0,1,0,0,0,0); chk("R8 one dropped", busy_cnt, 1); chk("R8 sending", tx_active, 1);
    step(0,0,1,0,0,0); chk("R8 total drop two", busy_cnt, 0); chk("R8 tx_bank advanced", tx_bank, 1);

    // R6 kill with nothing busy
    step(0,0,0,1,0,0); chk("R6 pending", kill_pend, 1);
    step(0,0,0,0,0,0); chk("R6 cleared", kill_pend, 0); chk("R6 count", busy_cnt, 0);

    // R7 refusal: bank already on the wire
    step(1,0,0,0,0,0); step(0,1,0,0,0,0); step(0,0,0,1,0,0);
    step(0,0,0,0,0,0); chk("R7 still pending", kill_pend, 1); chk("R7 count kept", busy_cnt, 1);
    step(0,0,1,0,0,0); chk("R7 sent clears", kill_pend, 0); chk("R7 count zero", busy_cnt, 0);

    // R7 refusal: token in the resolving cycle
    step(1,0,0,0,0,0); step(0,0,0,1,0,0);
    step(0,1,0,0,0,0); chk("R7 token race refused", kill_pend, 1); chk("R7 race count", busy_cnt, 1);
    step(0,0,1,0,0,0); chk("R7 race done", kill_pend, 0);

    // R4 second kill ignored while pending
    step(1,0,0,0,0,0); step(1,0,0,0,0,0); step(0,1,0,0,0,0);
    step(0,0,0,1,0,0); chk("R4 pending", kill_pend, 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit s;
      s = (m_send && ($urandom % 3 == 0)) || ($urandom % 32 == 0);
      step($urandom % 3 == 0, $urandom % 4 == 0, s, $urandom % 8 == 0,
           $urandom % 16 == 0, $urandom % 16 == 0);
    end
    finish_run();
  end
endmodule